// File: doc/BRIEF.md
# Floating-Point Status and Exception Flag Unit

This block owns the 32-bit status word that sits beside a single-precision arithmetic unit. Each time the arithmetic unit finishes an operation it presents a strobe together with its raw exception indications: invalid, divide-by-zero, overflow, underflow, inexact, denormal input and denormal output. The block replaces the per-operation cause field and accumulates sticky flags. It keeps a summary bit over the sticky flags. When an enabled cause appears, it raises a one-cycle exception request that carries vector number 21.

Software can also write the status word. Most fields simply take the written value. The cause field can only be cleared by a write, and the summary bit cannot be written at all. The low two bits select the rounding mode for the arithmetic unit. The block also turns an arithmetic result or a compare relation into the processor's zero, sign and overflow condition flags.

Status word layout:

| Bits | Content |
|------|---------|
| 1:0 | rounding mode |
| 6:2 | causes for invalid, divide-by-zero, overflow, underflow, inexact |
| 7 | unimplemented-processing cause |
| 8 | denormal flush control |
| 14:10 | enables, in the same order as the causes |
| 30:26 | sticky flags, in the same order as the causes |
| 31 | summary |

All other bits are plain storage.

Top module: `fpst_unit`

## Requirements
- R1: After reset, the status word reads 0, the rounding mode is 0, the exception request and vector are 0, and the condition flags cc_z, cc_s and cc_o are 0.
- R2: On an operation strobe (op_valid=1), the status word seen after the next rising edge has bits 6:2 equal to exc_in[4:0]. exc_in bit 0 is invalid, 1 is divide-by-zero, 2 is overflow, 3 is underflow and 4 is inexact. Cause bits set by an earlier operation are cleared. This holds for both arithmetic and compare operations.
- R3: For each condition i in 0..4 reported by an operation, sticky bit 26+i is set only if enable bit 10+i is 0. An operation never clears a sticky bit.
- R4: When exc_in[5] (denormal input) or exc_in[6] (denormal output) is 1, an operation sets cause bit 7, but only if flush bit 8 is 0. Otherwise bit 7 is cleared.
- R5: Status bit 31 equals the OR of sticky bits 30:26, after both writes and operations.
- R6: exc_request is high for exactly the one cycle after an operation whose new causes overlap the enables. Cause bit 7 counts as always enabled. exc_vector reads 21 while exc_request is high and 0 otherwise.
- R7: round_mode equals status bits 1:0. The encoding is 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity.
- R8: On a software write (sw_we=1), bit 31 of sw_wdata is ignored. Bits 1:0 and 30:8 take the written value. Bits 7:2 become the old value ANDed with the written value, so a write can clear them but never set them.
- R9: For a compare (op_is_cmp=1), cmp_rel is coded 0 for equal, 1 for less, 2 for greater and 3 for unordered. cc_z is 1 only for equal, cc_s is 1 only for less, and cc_o is 1 only for unordered.
- R10: For an arithmetic operation (op_is_cmp=0), cc_z is 1 when op_result[30:0] is zero and cc_s equals op_result[31]. cc_o keeps its value.
- R11: When op_valid and sw_we are high in the same cycle, the operation update is applied and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| op_valid | input | 1 | operation finished this cycle |
| op_is_cmp | input | 1 | operation is a compare |
| exc_in | input | 7 | raw exception indications (bit order in R2, R4) |
| op_result | input | 32 | arithmetic result bits |
| cmp_rel | input | 2 | compare relation (coding in R9) |
| sw_we | input | 1 | software write strobe |
| sw_wdata | input | 32 | software write data |
| status | output | 32 | status word |
| round_mode | output | 2 | rounding mode for the arithmetic unit |
| exc_request | output | 1 | one-cycle exception request |
| exc_vector | output | 8 | exception vector, 21 during a request |
| cc_z | output | 1 | zero condition flag |
| cc_s | output | 1 | sign condition flag |
| cc_o | output | 1 | overflow/unordered condition flag |

## Verification
Every piece of state is visible on the status port one edge after it changes. A wrongly kept cause, a lost sticky bit or a mis-gated enable therefore shows on the port at the very next sample. A fault in the exception-request path shows only in the single cycle after an operation, so the bench samples exc_request in exactly that cycle and again one cycle later. A corrupted flush or enable bit stays hidden until the following operation with a denormal or a matching condition. The bench arranges such operations right after each write.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned NCOND     = 5;
  localparam int unsigned RM_W      = 2;
  localparam int unsigned CAUSE_LSB = 2;
  localparam int unsigned CAUSE_W   = NCOND + 1;
  localparam int unsigned UNIMP_BIT = CAUSE_LSB + NCOND;
  localparam int unsigned DN_BIT    = 8;
  localparam int unsigned EN_LSB    = 10;
  localparam int unsigned STK_LSB   = 26;
  localparam int unsigned SUM_BIT   = STAT_W - 1;
  localparam int unsigned EXC_W     = NCOND + 2;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             dn_out;
    logic             dn_in;
    logic [NCOND-1:0] cond;
  } exc_t;
endpackage

// File: rtl/fpst_event.sv
module fpst_event
  import fpst_pkg::*;
(
  input  logic [SUM_BIT-1:0] old_q,
  input  exc_t               exc,
  output logic [SUM_BIT-1:0] next_q,
  output logic               req
);
  logic [NCOND-1:0] cause_c;
  logic [NCOND-1:0] stk_set;
  logic [NCOND-1:0] hit;
  logic             unimp;

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    assign cause_c[i] = exc.cond[i];
    assign stk_set[i] = exc.cond[i] & ~old_q[EN_LSB+i];
    assign hit[i]     = exc.cond[i] & old_q[EN_LSB+i];
  end

  assign unimp = (exc.dn_in | exc.dn_out) & ~old_q[DN_BIT];

  always_comb begin
    next_q                     = old_q;
    next_q[CAUSE_LSB +: NCOND] = cause_c;
    next_q[UNIMP_BIT]          = unimp;
    next_q[STK_LSB +: NCOND]   = old_q[STK_LSB +: NCOND] | stk_set;
  end

  // unimplemented-processing cause cannot be masked
  assign req = (|hit) | unimp;
endmodule

// File: rtl/fpst_swmerge.sv
module fpst_swmerge
  import fpst_pkg::*;
(
  input  logic [SUM_BIT-1:0] old_q,
  input  logic [SUM_BIT-1:0] wdata,
  output logic [SUM_BIT-1:0] next_q
);
  always_comb begin
    next_q = wdata;
    next_q[CAUSE_LSB +: CAUSE_W] = old_q[CAUSE_LSB +: CAUSE_W] & wdata[CAUSE_LSB +: CAUSE_W];
  end
endmodule

// File: rtl/fpst_cc.sv
module fpst_cc
  import fpst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_is_cmp,
  input  logic [1:0]        cmp_rel,
  input  logic [STAT_W-1:0] op_result,
  output logic              cc_z,
  output logic              cc_s,
  output logic              cc_o
);
  logic z_d, s_d, o_d;
  logic z_q, s_q, o_q;
  rel_e rel;

  assign rel = rel_e'(cmp_rel);

  always_comb begin
    z_d = z_q;
    s_d = s_q;
    o_d = o_q;
    if (op_valid) begin
      if (op_is_cmp) begin
        z_d = (rel == REL_EQ);
        s_d = (rel == REL_LT);
        o_d = (rel == REL_UN);
      end else begin
        z_d = (op_result[STAT_W-2:0] == '0);
        s_d = op_result[STAT_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      s_q <= 1'b0;
      o_q <= 1'b0;
    end else if (op_valid) begin
      z_q <= z_d;
      s_q <= s_d;
      o_q <= o_d;
    end
  end

  assign cc_z = z_q;
  assign cc_s = s_q;
  assign cc_o = o_q;

  // R9: a compare leaves at most one relation flag set
  a_r9_cmp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_cmp) |=> $onehot0({cc_z, cc_s, cc_o}));

  // R10: arithmetic leaves the overflow flag alone
  a_r10_o_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_cmp) |=> $stable(cc_o));
endmodule

// File: rtl/fpst_unit.sv
module fpst_unit
  import fpst_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned EXC_VEC = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_is_cmp,
  input  logic [EXC_W-1:0]  exc_in,
  input  logic [STAT_W-1:0] op_result,
  input  logic [1:0]        cmp_rel,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] status,
  output logic [RM_W-1:0]   round_mode,
  output logic              exc_request,
  output logic [VEC_W-1:0]  exc_vector,
  output logic              cc_z,
  output logic              cc_s,
  output logic              cc_o
);
  logic [SUM_BIT-1:0] stat_q, stat_d, ev_next, sw_next;
  logic               ev_req;
  logic               req_q, req_d;
  logic               stat_en;
  logic               unused_wbit;

  assign unused_wbit = sw_wdata[STAT_W-1];

  fpst_event i_event (
    .old_q  (stat_q),
    .exc    (exc_t'(exc_in)),
    .next_q (ev_next),
    .req    (ev_req)
  );

  fpst_swmerge i_swmerge (
    .old_q  (stat_q),
    .wdata  (sw_wdata[SUM_BIT-1:0]),
    .next_q (sw_next)
  );

  fpst_cc i_cc (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_is_cmp (op_is_cmp),
    .cmp_rel   (cmp_rel),
    .op_result (op_result),
    .cc_z      (cc_z),
    .cc_s      (cc_s),
    .cc_o      (cc_o)
  );

  // operation has priority over a colliding write
  always_comb begin
    stat_en = op_valid | sw_we;
    stat_d  = stat_q;
    if (op_valid)   stat_d = ev_next;
    else if (sw_we) stat_d = sw_next;
    req_d = op_valid & ev_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign status      = {(|stat_q[STK_LSB +: NCOND]), stat_q};
  assign round_mode  = stat_q[RM_W-1:0];
  assign exc_request = req_q;
  assign exc_vector  = req_q ? VEC_W'(EXC_VEC) : '0;

  // R8: a write alone never sets a cause bit
  a_r8_cause_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !op_valid) |=>
      ((status[CAUSE_LSB +: CAUSE_W] & ~$past(status[CAUSE_LSB +: CAUSE_W])) == '0));

  // R3: operations keep existing sticky bits
  a_r3_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((status[STK_LSB +: NCOND] & $past(status[STK_LSB +: NCOND]))
                  == $past(status[STK_LSB +: NCOND])));

  // R6: a request only follows an operation
  a_r6_req_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    exc_request |-> $past(op_valid));

  // R11: an operation never alters the rounding mode, even with a colliding write
  a_r11_op_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sw_we) |=> (round_mode == $past(round_mode)));
endmodule

// File: tb/test_fpst_unit.sv
module test_fpst_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        op_valid, op_is_cmp, sw_we;
  logic [6:0]  exc_in;
  logic [31:0] op_result, sw_wdata, status;
  logic [1:0]  cmp_rel, round_mode;
  logic        exc_request, cc_z, cc_s, cc_o;
  logic [7:0]  exc_vector;

  int checks = 0;
  int errors = 0;

  fpst_unit i_fpst_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
    .exc_in(exc_in), .op_result(op_result), .cmp_rel(cmp_rel),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status(status),
    .round_mode(round_mode), .exc_request(exc_request),
    .exc_vector(exc_vector), .cc_z(cc_z), .cc_s(cc_s), .cc_o(cc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; sw_we = 0; exc_in = '0; op_is_cmp = 0;
  endtask

  task automatic swr(input logic [31:0] d);
    sw_we = 1; sw_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic op(input logic cmp, input logic [6:0] e,
                    input logic [31:0] res, input logic [1:0] rel);
    op_valid = 1; op_is_cmp = cmp; exc_in = e; op_result = res; cmp_rel = rel;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 round_mode", {30'd0, round_mode}, 32'h0);
    chk("R1 req", {23'd0, exc_request, exc_vector}, 32'h0);
    chk("R1 flags", {29'd0, cc_z, cc_s, cc_o}, 32'h0);
  endtask

  task automatic t_write();
    swr(32'hFFFF_FFFF);
    chk("R8 write all ones", status, 32'hFFFF_FF03);
    chk("R5 summary on write", {31'd0, status[31]}, 32'h1);
    chk("R7 mode 3", {30'd0, round_mode}, 32'h3);
    swr(32'h8000_0000);
    chk("R5 summary cleared, bit31 ignored R8", status, 32'h0);
    swr(32'h0000_0001);
    chk("R7 mode 1", {30'd0, round_mode}, 32'h1);
    swr(32'h0000_0002);
    chk("R7 mode 2", {30'd0, round_mode}, 32'h2);
    swr(32'h0);
  endtask

  task automatic t_arith();
    op(0, 7'b0010001, 32'h8000_0000, 2'd0);
    chk("R2 R3 invalid+inexact", status, 32'hC400_0044);
    chk("R6 masked no req", {31'd0, exc_request}, 32'h0);
    chk("R10 neg zero", {30'd0, cc_z, cc_s}, 32'h3);
    op(0, 7'b0000000, 32'h3F80_0000, 2'd0);
    chk("R2 causes cleared", status, 32'hC400_0000);
    chk("R10 positive", {30'd0, cc_z, cc_s}, 32'h0);
  endtask

  task automatic t_enable();
    swr(32'h0000_1000);
    chk("R8 enable written", status, 32'h0000_1000);
    op(0, 7'b0000100, 32'h1, 2'd0);
    chk("R3 enabled no sticky", status, 32'h0000_1010);
    chk("R6 req", {23'd0, exc_request, exc_vector}, {23'd0, 1'b1, 8'd21});
    @(negedge clk);
    chk("R6 single pulse", {23'd0, exc_request, exc_vector}, 32'h0);
    swr(32'h0000_10FC);
    chk("R8 cause cannot be set", status, 32'h0000_1010);
    swr(32'h0000_1000);
    chk("R8 cause cleared", status, 32'h0000_1000);
  endtask

  task automatic t_denorm();
    op(0, 7'b0100000, 32'h1, 2'd0);
    chk("R4 unimpl cause", status, 32'h0000_1080);
    chk("R6 unimpl always enabled", {31'd0, exc_request}, 32'h1);
    swr(32'h0000_0100);
    op(0, 7'b1000000, 32'h1, 2'd0);
    chk("R4 flushed no cause", status, 32'h0000_0100);
    chk("R4 flushed no req", {31'd0, exc_request}, 32'h0);
    swr(32'h0);
  endtask

  task automatic t_compare();
    op(1, 7'd0, 32'h0, 2'd0);
    chk("R9 equal", {29'd0, cc_z, cc_s, cc_o}, 32'h4);
    op(1, 7'd0, 32'h0, 2'd1);
    chk("R9 less", {29'd0, cc_z, cc_s, cc_o}, 32'h2);
    op(1, 7'd0, 32'h0, 2'd2);
    chk("R9 greater", {29'd0, cc_z, cc_s, cc_o}, 32'h0);
    op(1, 7'b0000001, 32'h0, 2'd3);
    chk("R9 unordered", {29'd0, cc_z, cc_s, cc_o}, 32'h1);
    chk("R2 compare records cause", status, 32'h8400_0004);
    op(0, 7'd0, 32'h0000_0001, 2'd0);
    chk("R10 O kept", {29'd0, cc_z, cc_s, cc_o}, 32'h1);
  endtask

  task automatic t_collide();
    op_valid = 1; op_is_cmp = 0; exc_in = 7'd0; op_result = 32'h1;
    sw_we = 1; sw_wdata = 32'h0000_0003;
    @(negedge clk);
    idle();
    chk("R11 op wins", status, 32'h8400_0000);
    chk("R11 mode unchanged", {30'd0, round_mode}, 32'h0);
  endtask

  initial begin
    rst_n = 0; idle(); op_result = '0; cmp_rel = '0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_arith();
    t_enable();
    t_denorm();
    t_compare();
    t_collide();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule